// File: doc/BRIEF.md
# Partitioned SIMD Lane Adder

This block adds two 128-bit vectors as a set of independent lanes. A 2-bit size code chosen per operation selects the lane width: 8, 16 or 32 bits. That gives sixteen, eight or four lanes, because the lane count is the word width divided by the element width. The block has one segmented carry chain made of byte-wide slices. A break signal decoded from the size code cuts the chain at each lane edge, so carries stay inside their lane. The same slices serve every lane width.

Operands come in over a valid/ready stream, and the sum leaves over a second valid/ready stream. One output register sits between the two.

- An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or its current contents are being taken in the same cycle.
- Once `res_valid` is raised, `res_data` holds unchanged until the consumer asserts `res_ready`.
- A consumer that holds `res_ready` high sees one result per cycle, one cycle after each accepted operation.

Top module: `simd_lane_adder`

## Requirements
- R1: Size code 00 splits the word into sixteen 8-bit lanes. Lane i occupies bits 8i+7 down to 8i, so lane 0 holds the least significant bits. Each lane of the result is the sum of the same lane of both operands, modulo 256.
- R2: Size code 01 splits the word into eight 16-bit lanes. Lane i occupies bits 16i+15 down to 16i, and each lane sum wraps modulo 65536.
- R3: Size code 10 splits the word into four 32-bit lanes. Lane i occupies bits 32i+31 down to 32i, and each lane sum wraps modulo 2^32.
- R4: Size code 11 behaves exactly like size code 10.
- R5: The carry out of the top bit of a lane is discarded and never reaches the next lane. This holds even when every lane overflows at once.
- R6: An operation accepted on a rising edge presents its sum on `res_data`, with `res_valid` high, right after that edge.
- R7: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_data` does not change.
- R8: `in_ready` equals (not `res_valid`) or `res_ready`. An operation is taken only when `in_valid` and `in_ready` are both high.
- R9: A synchronous active-high `rst` clears `res_valid`, which leaves `in_ready` high.
- R10: When a result is taken and no new operation is accepted on the same edge, `res_valid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| op_a | input | 128 | First operand vector |
| op_b | input | 128 | Second operand vector |
| elem_size | input | 2 | Lane width: 00 = 8, 01 = 16, 10 or 11 = 32 |
| res_valid | output | 1 | Result register holds a sum |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_data | output | 128 | Lane-wise sum |

## Verification
The hardest case to reach from the ports is a carry that is legal in one lane width but must be blocked in another.

- The stimulus uses operand pairs in which every byte overflows, such as all ones plus a one in every byte.
- It replays the same operand pair under all four size codes back to back.
- If a break is missing or misplaced, a carry leaks into the neighbouring lane and the lane-by-lane reference disagrees.

Random stalls on `res_ready` are mixed with these operations, so mode switches also happen while a result is held.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    ESZ_B8   = 2'b00,
    ESZ_B16  = 2'b01,
    ESZ_B32  = 2'b10,
    ESZ_B32X = 2'b11
  } esize_e;

  // number of byte slices that make up one lane
  function automatic int unsigned slices_per_lane(esize_e s);
    case (s)
      ESZ_B8:  return 1;
      ESZ_B16: return 2;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/lane_break_decode.sv
module lane_break_decode
  import simd_pkg::*;
#(
  parameter int NSEG = 16
) (
  input  esize_e          esize,
  output logic [NSEG-2:0] brk   // brk[k]: cut carry into slice k+1
);
  int unsigned spl;

  always_comb begin
    spl = slices_per_lane(esize);
    for (int k = 1; k < NSEG; k++) begin
      brk[k-1] = ((k & (spl - 1)) == 0);
    end
  end
endmodule

// File: rtl/seg_carry_adder.sv
module seg_carry_adder #(
  parameter int SEG_W = 8,
  parameter int NSEG  = 16,
  localparam int W    = SEG_W * NSEG
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [NSEG-2:0] brk,
  output logic [W-1:0]    sum
);
  logic [NSEG-2:0] cout;

  for (genvar k = 0; k < NSEG; k++) begin : g_slice
    logic cin;
    if (k == 0) begin : g_first
      assign cin = 1'b0;
    end else begin : g_link
      assign cin = cout[k-1] & ~brk[k-1];
    end

    if (k == NSEG - 1) begin : g_top
      assign sum[k*SEG_W +: SEG_W] =
        a[k*SEG_W +: SEG_W] + b[k*SEG_W +: SEG_W] + SEG_W'(cin);
    end else begin : g_mid
      logic [SEG_W:0] part;
      assign part = {1'b0, a[k*SEG_W +: SEG_W]} + {1'b0, b[k*SEG_W +: SEG_W]}
                  + {{SEG_W{1'b0}}, cin};
      assign sum[k*SEG_W +: SEG_W] = part[SEG_W-1:0];
      assign cout[k] = part[SEG_W];
    end
  end
endmodule

// File: rtl/result_stage.sv
module result_stage #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      out_data <= in_data;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7
  AST_ACCEPT_LAT: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid); // R6
  AST_RESET_CLR: assert property (@(posedge clk)
    rst |=> !out_valid); // R9
  AST_DRAIN_FALL: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !in_valid |=> !out_valid); // R10
endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
  import simd_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int SEG_W  = 8,
  localparam int NSEG  = DATA_W / SEG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [1:0]        elem_size,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data
);
  esize_e            esz;
  logic [NSEG-2:0]   brk;
  logic [DATA_W-1:0] lane_sum;

  assign esz = esize_e'(elem_size);

  lane_break_decode #(.NSEG(NSEG)) u_dec (
    .esize (esz),
    .brk   (brk)
  );

  seg_carry_adder #(.SEG_W(SEG_W), .NSEG(NSEG)) u_add (
    .a   (op_a),
    .b   (op_b),
    .brk (brk),
    .sum (lane_sum)
  );

  result_stage #(.W(DATA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (lane_sum),
    .out_valid (res_valid),
    .out_ready (res_ready),
    .out_data  (res_data)
  );

  AST_BRK8: assert property (@(posedge clk) disable iff (rst)
    elem_size == 2'b00 |-> $countones(brk) == NSEG - 1); // R1
  AST_BRK16: assert property (@(posedge clk) disable iff (rst)
    elem_size == 2'b01 |-> $countones(brk) == NSEG / 2 - 1); // R2
  AST_BRK32: assert property (@(posedge clk) disable iff (rst)
    elem_size[1] |-> $countones(brk) == NSEG / 4 - 1); // R3
endmodule

// File: tb/simd_lane_adder_tb_top.sv
module simd_lane_adder_tb_top;
  localparam int CLK_P = 10;
  localparam int W = 128;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [1:0]   elem_size = 2'b00;
  logic         res_valid;
  logic         res_ready = 1'b1;
  logic [W-1:0] res_data;

  int  n_tests = 0;
  int  n_fail = 0;
  bit  done = 0;

  logic         exp_valid = 1'b0;
  logic [W-1:0] exp_data = '0;
  logic [1:0]   exp_code = 2'b00;

  always #(CLK_P/2) clk = ~clk;

  simd_lane_adder dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .elem_size(elem_size),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  function automatic logic [W-1:0] ref_add(logic [W-1:0] a, logic [W-1:0] b,
                                           logic [1:0] code);
    int w;
    logic [W-1:0] m, r, s;
    w = (code == 2'b00) ? 8 : (code == 2'b01) ? 16 : 32;
    m = (W'(1) << w) - W'(1);
    r = '0;
    for (int l = 0; l < W / w; l++) begin
      s = (((a >> (l*w)) & m) + ((b >> (l*w)) & m)) & m;
      r = r | (s << (l*w));
    end
    return r;
  endfunction

  function automatic string tag_of(logic [1:0] c);
    case (c)
      2'b00: return "R1 R5";
      2'b01: return "R2 R5";
      2'b10: return "R3 R5";
      default: return "R4 R5";
    endcase
  endfunction

  // behavioural model of the stream register
  always @(posedge clk) begin
    if (rst) begin
      exp_valid <= 1'b0;
    end else if (!exp_valid || res_ready) begin
      exp_valid <= in_valid;
      if (in_valid) begin
        exp_data <= ref_add(op_a, op_b, elem_size);
        exp_code <= elem_size;
      end
    end
  end

  task automatic check_bit(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_vec(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check_bit("R6 R10 valid", res_valid, exp_valid);
      check_bit("R8 ready", in_ready, !exp_valid || res_ready);
      if (exp_valid) check_vec(tag_of(exp_code), res_data, exp_data);
    end
  end

  task automatic offer(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] c);
    @(negedge clk);
    #1;
    op_a = a; op_b = b; elem_size = c; in_valid = 1'b1;
    do @(posedge clk); while (!in_ready);
    #1;
    in_valid = 1'b0;
  endtask

  initial begin
    logic [W-1:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_bit("R9 reset valid", res_valid, 1'b0);
    check_bit("R9 reset ready", in_ready, 1'b1);
    rst = 1'b0;

    // every lane overflows, each size code on the same operands
    for (int c = 0; c < 4; c++) offer({W{1'b1}}, {16{8'h01}}, 2'(c));
    for (int c = 0; c < 4; c++) offer({16{8'h80}}, {16{8'h80}}, 2'(c));
    for (int c = 0; c < 4; c++) offer({8{16'hFFFF}}, {8{16'h0001}}, 2'(c));
    for (int c = 0; c < 4; c++) offer({4{32'hFFFF_FFFF}}, {4{32'h0000_0001}}, 2'(c));
    // lane 0 position: only the lowest byte non-zero (R1)
    offer(W'(8'hFF), W'(8'h02), 2'b00);
    offer(W'(8'hFF), W'(8'h02), 2'b01);

    // stall: hold result while consumer is not ready (R7)
    @(negedge clk); #1;
    res_ready = 1'b0;
    op_a = {W{1'b1}}; op_b = {W{1'b1}}; elem_size = 2'b01; in_valid = 1'b1;
    @(posedge clk); #1;
    op_a = '0; op_b = {W{1'b1}}; elem_size = 2'b10;
    @(negedge clk);
    held = res_data;
    repeat (4) @(negedge clk);
    check_vec("R7 hold", res_data, held);
    check_bit("R7 valid held", res_valid, 1'b1);
    #1; res_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check_bit("R10 drained", res_valid, 1'b0);

    // random stream with random back-pressure
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      in_valid  = ($urandom_range(0, 3) != 0);
      res_ready = ($urandom_range(0, 3) != 0);
      op_a = {$urandom, $urandom, $urandom, $urandom};
      op_b = {$urandom, $urandom, $urandom, $urandom};
      elem_size = 2'($urandom_range(0, 3));
    end
    @(negedge clk); #1;
    in_valid = 1'b0; res_ready = 1'b1;
    repeat (3) @(negedge clk);

    // reset while holding a result (R9)
    #1; res_ready = 1'b0; in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0; rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check_bit("R9 reset clears", res_valid, 1'b0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule